// File: doc/BRIEF.md
# Dual-Channel Event Performance Counter

This block is a two-channel hardware performance monitor for a processor core. Each cycle the core presents a set of one-bit event strobes, such as cache accesses and misses, TLB misses, fetches, issues, dual issues, interrupts and fill cycles. Index 0 of the internal event vector is reserved for elapsed cycles and is always active. Each channel picks one event and adds it into a wide saturating counter.

A channel can add 1 per event, or it can add a weight taken from the current core-to-bus clock ratio code. In the second case the count stays proportional to bus time even when software changes the ratio while the program runs. Elapsed time is then the count multiplied by the bus period and divided by 24.

A channel can count over the whole run, or only inside a window. The window is bounded by a start PC and an end PC, and both channels share one such pair. Software configures the block through a small register port. Through the same port it reads each count as a low word and a high word, and issues an initialise command.

Top module: `evt_perf_mon`

## Requirements
- R1: After reset, both counts are zero, both overflow flags are clear, the window is closed, and the control, start-PC and end-PC registers read as zero.
- R2: A channel counts in a cycle only when its selected event is active and `run_i` is high. Select 0 is elapsed cycles and is always active. Select n (n ≥ 1) follows `evt_i[n-1]`.
- R3: In unit mode (ratio bit 0) each counted cycle adds exactly 1.
- R4: In ratio mode (ratio bit 1), each counted cycle adds a weight chosen by `ratio_i`: code 0 adds 3, 1 adds 4, 2 adds 6, 3 adds 8, 4 adds 12, and 5, 6 and 7 add 24.
- R5: A valid PC equal to the start PC opens the window from the next cycle on. A valid PC equal to the end PC closes it, and that cycle is not counted. When both match in the same cycle, the close wins. A channel in window mode counts only while the window is open.
- R6: A channel in full-run mode ignores the window and counts whenever R2 allows.
- R7: Both channels share a single start/end PC pair. Each write replaces the stored value, so the last write wins, and the registers read back what was written.
- R8: If an addition would pass the counter's maximum, the counter stops at all ones and its overflow flag is set. The flag stays set through further events and is cleared only by the initialise command.
- R9: A write to address 4 (initialise) clears both counts and both overflow flags. This takes priority over any event in the same cycle.
- R10: The register map is as follows.
  - Address 0 and address 1 are the control registers of channel 0 and channel 1. Bits [SEL_W-1:0] hold the event select, bit SEL_W holds the ratio bit and bit SEL_W+1 holds the window bit.
  - Address 2 is the start PC and address 3 is the end PC.
  - A read of address 4 returns status: bit 0 is the channel 0 overflow flag, bit 1 is the channel 1 overflow flag, and bit 2 is the window state.
  - Addresses 5 and 6 return the low and high words of count 0. Addresses 7 and 8 return the low and high words of count 1.
- R11: The two channels are independent. Each follows its own select and modes in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | NUM_EVT-1 | Event strobes for selects 1 and up |
| run_i | input | 1 | High while the program runs |
| pc_vld_i | input | 1 | Retiring PC is valid |
| pc_i | input | PC_W | Retiring PC |
| ratio_i | input | 3 | Core-to-bus clock ratio code |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | DATA_W | Register write data |
| reg_rdata_o | output | DATA_W | Register read data (combinational) |

## Verification
Two register functions are exercised in the same cycle as counting.

The first is the initialise command. It is issued while the selected event is active and `run_i` is high, so a clear and an addition fall on the same edge. The expected outcome is a zero count on both channels, with the flags cleared, and counting resuming on the next cycle.

The second is the window logic. The start PC and the end PC can be presented together, and the end PC can arrive while the window is open. The bench models the window from the requirement: the close wins, and the end cycle is not counted. It compares a window-mode channel against a full-run channel on the same events.

The main sweep covers every event select, both add modes and all eight ratio codes, with patterned events and run gaps.

// File: rtl/epm_pkg.sv
package epm_pkg;

   // register addresses
   localparam logic [3:0] A_CTL0  = 4'd0;
   localparam logic [3:0] A_CTL1  = 4'd1;
   localparam logic [3:0] A_START = 4'd2;
   localparam logic [3:0] A_END   = 4'd3;
   localparam logic [3:0] A_CMD   = 4'd4;
   localparam logic [3:0] A_C0LO  = 4'd5;
   localparam logic [3:0] A_C0HI  = 4'd6;
   localparam logic [3:0] A_C1LO  = 4'd7;
   localparam logic [3:0] A_C1HI  = 4'd8;

   localparam int WGT_W   = 5;
   localparam int WGT_MAX = 24;

   // per-event weight for the clock-ratio mode
   function automatic logic [WGT_W-1:0] ratio_weight(input logic [2:0] code);
      case (code)
         3'd0:    ratio_weight = 5'd3;
         3'd1:    ratio_weight = 5'd4;
         3'd2:    ratio_weight = 5'd6;
         3'd3:    ratio_weight = 5'd8;
         3'd4:    ratio_weight = 5'd12;
         default: ratio_weight = 5'd24;
      endcase
   endfunction

endpackage

// File: rtl/epm_window.sv
module epm_window #(
   parameter int PC_W = 32
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            pc_vld_i,
   input  logic [PC_W-1:0] pc_i,
   input  logic [PC_W-1:0] start_i,
   input  logic [PC_W-1:0] end_i,
   output logic            active_o,
   output logic            state_o
);

   logic win_q;
   logic start_hit;
   logic end_hit;

   assign start_hit = pc_vld_i && (pc_i == start_i);
   assign end_hit   = pc_vld_i && (pc_i == end_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         win_q <= 1'b0;
      else if (end_hit)
         win_q <= 1'b0;
      else if (start_hit)
         win_q <= 1'b1;
   end

   // the end cycle itself is excluded from the window
   assign active_o = win_q && !end_hit;
   assign state_o  = win_q;

   a_r5_open_after_start: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_vld_i && pc_i == start_i && pc_i != end_i) |=> state_o);

   a_r5_close_on_end: assert property (@(posedge clk) disable iff (!rst_n)
      (pc_vld_i && pc_i == end_i) |=> !state_o);

   a_r5_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
      (!pc_vld_i) |=> $stable(state_o));

endmodule

// File: rtl/epm_channel.sv
module epm_channel #(
   parameter int NUM_EVT = 16,
   parameter int CNT_W   = 48
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     clr_i,
   input  logic [$clog2(NUM_EVT)-1:0] sel_i,
   input  logic                     ratio_mode_i,
   input  logic                     win_mode_i,
   input  logic [NUM_EVT-1:0]       evt_vec_i,
   input  logic                     run_i,
   input  logic                     win_active_i,
   input  logic [epm_pkg::WGT_W-1:0] weight_i,
   output logic [CNT_W-1:0]         cnt_o,
   output logic                     ovf_o
);
   import epm_pkg::*;

   localparam int SUM_W = CNT_W + 1;

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             evt_hit;
   logic             in_range;
   logic             hit;
   logic [WGT_W-1:0] step;
   logic [SUM_W-1:0] sum;

   assign evt_hit  = evt_vec_i[sel_i];
   assign in_range = win_mode_i ? win_active_i : 1'b1;
   assign hit      = evt_hit && run_i && in_range;
   assign step     = ratio_mode_i ? weight_i : WGT_W'(1);
   assign sum      = {1'b0, cnt_q} + SUM_W'(step);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (clr_i) begin
         cnt_q <= '0;
         ovf_q <= 1'b0;
      end else if (hit) begin
         if (sum[CNT_W]) begin
            cnt_q <= '1;
            ovf_q <= 1'b1;
         end else begin
            cnt_q <= sum[CNT_W-1:0];
         end
      end
   end

   assign cnt_o = cnt_q;
   assign ovf_o = ovf_q;

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_o && !clr_i) |=> ovf_o);

   a_r8_saturated: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_o) |-> (&cnt_o));

   a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_o == '0 && !ovf_o));

   a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_i && !clr_i) |=> $stable(cnt_o));

   a_r4_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (!clr_i) |=> (cnt_o >= $past(cnt_o) &&
                    (cnt_o - $past(cnt_o)) <= CNT_W'(WGT_MAX)));

endmodule

// File: rtl/evt_perf_mon.sv
module evt_perf_mon #(
   parameter int NUM_EVT = 16,
   parameter int CNT_W   = 48,
   parameter int DATA_W  = 32,
   parameter int PC_W    = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_EVT-2:0] evt_i,
   input  logic              run_i,
   input  logic              pc_vld_i,
   input  logic [PC_W-1:0]   pc_i,
   input  logic [2:0]        ratio_i,
   input  logic              reg_we_i,
   input  logic [3:0]        reg_addr_i,
   input  logic [DATA_W-1:0] reg_wdata_i,
   output logic [DATA_W-1:0] reg_rdata_o
);
   import epm_pkg::*;

   localparam int SEL_W = $clog2(NUM_EVT);
   localparam int EXT_W = 2 * DATA_W;
   localparam int NCH   = 2;

   if (NUM_EVT < 2 || NUM_EVT != (1 << SEL_W)) begin : g_bad_evt
      $error("NUM_EVT must be a power of two of at least 2");
   end
   if (CNT_W <= DATA_W || CNT_W > EXT_W) begin : g_bad_cnt
      $error("CNT_W must lie in (DATA_W, 2*DATA_W]");
   end
   if (SEL_W + 2 > DATA_W || PC_W > DATA_W || DATA_W < 3) begin : g_bad_data
      $error("DATA_W too narrow for control, PC or status fields");
   end

   logic [SEL_W-1:0]  sel_q   [NCH];
   logic              ratio_q [NCH];
   logic              win_q   [NCH];
   logic [PC_W-1:0]   start_q;
   logic [PC_W-1:0]   end_q;
   logic [NCH-1:0]    ctl_wr;
   logic              init_cmd;
   logic [NUM_EVT-1:0] evt_vec;
   logic [WGT_W-1:0]  weight;
   logic              win_active;
   logic              win_state;
   logic [CNT_W-1:0]  cnt   [NCH];
   logic [NCH-1:0]    ovf;
   logic [EXT_W-1:0]  cnt_ext [NCH];
   logic [DATA_W-1:0] ctl_rd  [NCH];

   assign evt_vec  = {evt_i, 1'b1};          // index 0: elapsed cycles
   assign weight   = ratio_weight(ratio_i);
   assign init_cmd = reg_we_i && (reg_addr_i == A_CMD);
   assign ctl_wr[0] = reg_we_i && (reg_addr_i == A_CTL0);
   assign ctl_wr[1] = reg_we_i && (reg_addr_i == A_CTL1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         start_q <= '0;
         end_q   <= '0;
      end else if (reg_we_i) begin
         if (reg_addr_i == A_START) start_q <= reg_wdata_i[PC_W-1:0];
         if (reg_addr_i == A_END)   end_q   <= reg_wdata_i[PC_W-1:0];
      end
   end

   epm_window #(.PC_W(PC_W)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .pc_vld_i (pc_vld_i),
      .pc_i     (pc_i),
      .start_i  (start_q),
      .end_i    (end_q),
      .active_o (win_active),
      .state_o  (win_state)
   );

   for (genvar c = 0; c < NCH; c++) begin : g_ch
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            sel_q[c]   <= '0;
            ratio_q[c] <= 1'b0;
            win_q[c]   <= 1'b0;
         end else if (ctl_wr[c]) begin
            sel_q[c]   <= reg_wdata_i[SEL_W-1:0];
            ratio_q[c] <= reg_wdata_i[SEL_W];
            win_q[c]   <= reg_wdata_i[SEL_W+1];
         end
      end

      always_comb begin
         ctl_rd[c] = '0;
         ctl_rd[c][SEL_W-1:0] = sel_q[c];
         ctl_rd[c][SEL_W]     = ratio_q[c];
         ctl_rd[c][SEL_W+1]   = win_q[c];
      end

      epm_channel #(.NUM_EVT(NUM_EVT), .CNT_W(CNT_W)) u_ch (
         .clk          (clk),
         .rst_n        (rst_n),
         .clr_i        (init_cmd),
         .sel_i        (sel_q[c]),
         .ratio_mode_i (ratio_q[c]),
         .win_mode_i   (win_q[c]),
         .evt_vec_i    (evt_vec),
         .run_i        (run_i),
         .win_active_i (win_active),
         .weight_i     (weight),
         .cnt_o        (cnt[c]),
         .ovf_o        (ovf[c])
      );

      assign cnt_ext[c] = EXT_W'(cnt[c]);
   end

   always_comb begin
      reg_rdata_o = '0;
      case (reg_addr_i)
         A_CTL0:  reg_rdata_o = ctl_rd[0];
         A_CTL1:  reg_rdata_o = ctl_rd[1];
         A_START: reg_rdata_o = DATA_W'(start_q);
         A_END:   reg_rdata_o = DATA_W'(end_q);
         A_CMD:   reg_rdata_o = DATA_W'({win_state, ovf});
         A_C0LO:  reg_rdata_o = cnt_ext[0][DATA_W-1:0];
         A_C0HI:  reg_rdata_o = cnt_ext[0][EXT_W-1:DATA_W];
         A_C1LO:  reg_rdata_o = cnt_ext[1][DATA_W-1:0];
         A_C1HI:  reg_rdata_o = cnt_ext[1][EXT_W-1:DATA_W];
         default: reg_rdata_o = '0;
      endcase
   end

   a_r7_start_last_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_i && reg_addr_i == A_START) |=> (start_q == $past(reg_wdata_i[PC_W-1:0])));

   a_r7_end_last_write: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_we_i && reg_addr_i == A_END) |=> (end_q == $past(reg_wdata_i[PC_W-1:0])));

   a_r9_init_both: assert property (@(posedge clk) disable iff (!rst_n)
      init_cmd |=> (ovf == 2'b00 && cnt[0] == '0 && cnt[1] == '0));

endmodule

// File: tb/evt_perf_mon_test.sv
`timescale 1ns/1ps
module evt_perf_mon_test;

   localparam int NE  = 4;
   localparam int CW  = 12;
   localparam int DW  = 8;
   localparam int PW  = 8;
   localparam int MAXC = (1 << CW) - 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NE-2:0] evt = '0;
   logic          run = 1'b0;
   logic          pcv = 1'b0;
   logic [PW-1:0] pc = '0;
   logic [2:0]    rat = '0;
   logic          we = 1'b0;
   logic [3:0]    addr = '0;
   logic [DW-1:0] wdata = '0;
   logic [DW-1:0] rdata;

   int n_chk = 0;
   int n_fail = 0;

   // model state
   int  mcnt [2];
   bit  movf [2];
   int  msel [2];
   bit  mrat [2];
   bit  mwin [2];
   int  mstart = 0, mend = 0;
   bit  mopen = 0;

   always #10 clk = ~clk;

   evt_perf_mon #(.NUM_EVT(NE), .CNT_W(CW), .DATA_W(DW), .PC_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .evt_i(evt), .run_i(run), .pc_vld_i(pcv),
      .pc_i(pc), .ratio_i(rat), .reg_we_i(we), .reg_addr_i(addr),
      .reg_wdata_i(wdata), .reg_rdata_o(rdata));

   function automatic int wgt(input int code);
      case (code)
         0: return 3;
         1: return 4;
         2: return 6;
         3: return 8;
         4: return 12;
         default: return 24;
      endcase
   endfunction

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   task automatic chk(input string tag, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_fail++;
         $display("FAIL %s: got %0d expected %0d", tag, got, exp);
      end
   endtask

   // one clock: model computed from pre-edge inputs, committed after the edge
   task automatic tick();
      int  nc [2];
      bit  no [2];
      bit  nopen;
      bit  endhit, starthit, act;
      endhit   = pcv && (int'(pc) == mend);
      starthit = pcv && (int'(pc) == mstart);
      act      = mopen && !endhit;
      for (int k = 0; k < 2; k++) begin
         bit ev, hit;
         int inc;
         ev  = (msel[k] == 0) ? 1'b1 : evt[msel[k]-1];
         hit = ev && run && (mwin[k] ? act : 1'b1);
         inc = mrat[k] ? wgt(int'(rat)) : 1;
         nc[k] = mcnt[k];
         no[k] = movf[k];
         if (we && addr == 4'd4) begin
            nc[k] = 0;
            no[k] = 0;
         end else if (hit) begin
            if (mcnt[k] + inc > MAXC) begin
               nc[k] = MAXC;
               no[k] = 1;
            end else begin
               nc[k] = mcnt[k] + inc;
            end
         end
      end
      nopen = endhit ? 1'b0 : (starthit ? 1'b1 : mopen);
      @(posedge clk);
      #1;
      mcnt[0] = nc[0]; mcnt[1] = nc[1];
      movf[0] = no[0]; movf[1] = no[1];
      mopen = nopen;
      if (we) begin
         case (addr)
            4'd0, 4'd1: begin
               msel[addr] = int'(wdata[1:0]);
               mrat[addr] = wdata[2];
               mwin[addr] = wdata[3];
            end
            4'd2: mstart = int'(wdata);
            4'd3: mend = int'(wdata);
            default: ;
         endcase
      end
   endtask

   task automatic wr(input logic [3:0] a, input logic [DW-1:0] d);
      we = 1'b1; addr = a; wdata = d;
      tick();
      we = 1'b0;
   endtask

   task automatic rd(input logic [3:0] a, output int v);
      addr = a;
      #1;
      v = int'(rdata);
   endtask

   task automatic check_all(input string tag);
      int v;
      rd(4'd5, v); chk({tag, " c0 low"},  v, mcnt[0] & 255);
      rd(4'd6, v); chk({tag, " c0 high"}, v, mcnt[0] >> 8);
      rd(4'd7, v); chk({tag, " c1 low"},  v, mcnt[1] & 255);
      rd(4'd8, v); chk({tag, " c1 high"}, v, mcnt[1] >> 8);
      rd(4'd4, v); chk({tag, " status"},  v, (int'(mopen) << 2) | (int'(movf[1]) << 1) | int'(movf[0]));
   endtask

   initial begin
      #2_000_000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      int v;
      for (int k = 0; k < 2; k++) begin
         mcnt[k] = 0; movf[k] = 0; msel[k] = 0; mrat[k] = 0; mwin[k] = 0;
      end
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;

      // R1: reset state
      check_all("R1");
      for (int a = 0; a < 4; a++) begin
         rd(4'(a), v); chk("R1 config reg", v, 0);
      end

      // R2 R3 R4 R11 R10: sweep selects, add modes and ratio codes
      for (int sm = 0; sm < 4; sm++) begin
         for (int md = 0; md < 2; md++) begin
            for (int r = 0; r < 8; r++) begin
               run = 1'b0;
               wr(4'd0, DW'((md << 2) | sm));
               wr(4'd1, DW'(((1 - md) << 2) | ((sm + 1) % 4)));
               wr(4'd4, '0);
               rat = 3'(r);
               for (int i = 0; i < 24; i++) begin
                  evt = 3'((i * 5) ^ (i >> 1));
                  run = ((i % 7) != 3);
                  tick();
               end
               run = 1'b0;
               check_all("R2 R3 R4 R11 R10");
            end
         end
      end
      rd(4'd0, v); chk("R10 ctl0 readback", v, (1 << 2) | 3);

      // R5 R6: window channel 0, full-run channel 1, both elapsed cycles, unit
      wr(4'd0, DW'(8'b1000));
      wr(4'd1, DW'(8'b0000));
      wr(4'd2, 8'h10);
      wr(4'd3, 8'h20);
      wr(4'd4, '0);
      run = 1'b1;
      begin
         int seq [14] = '{8'h05, 8'h10, 8'h11, 8'h12, 8'h20, 8'h21, 8'h10,
                          8'h13, 8'h13, 8'h33, 8'h14, 8'h20, 8'h10, 8'h15};
         for (int i = 0; i < 14; i++) begin
            pc  = PW'(seq[i]);
            pcv = (i != 9);
            tick();
            if (i == 1) check_all("R5 window opened");
         end
      end
      pcv = 1'b0;
      run = 1'b0;
      check_all("R5 R6 window span");
      // start and end in the same cycle: close wins
      wr(4'd3, 8'h10);
      pcv = 1'b1; pc = 8'h10; run = 1'b1;
      tick();
      pcv = 1'b0;
      tick();
      run = 1'b0;
      check_all("R5 start equals end");

      // R7: last write wins
      wr(4'd2, 8'h44);
      wr(4'd2, 8'h5A);
      rd(4'd2, v); chk("R7 start last write", v, 8'h5A);
      rd(4'd3, v); chk("R7 end kept", v, 8'h10);

      // R8: overflow saturates, sticky flag
      wr(4'd0, DW'(8'b0100));
      wr(4'd1, DW'(8'b0000));
      wr(4'd4, '0);
      rat = 3'd5;
      run = 1'b1;
      for (int i = 0; i < 200; i++) tick();
      check_all("R8 saturate");
      rd(4'd4, v); chk("R8 flag0 set", v & 1, 1);
      for (int i = 0; i < 5; i++) tick();
      check_all("R8 sticky");

      // R9: initialise in a cycle with an active event
      wr(4'd4, '0);
      check_all("R9 init beats event");
      tick();
      run = 1'b0;
      check_all("R9 resume");

      summary();
      $finish;
   end

endmodule